// File: doc/BRIEF.md
# Multiplexed Scope Display Sequencer

The sequencer replays a buffer of captured multi-bit logic samples on one analog oscilloscope input, so that the screen shows several stacked digital traces. It drives the read address of the sample memory and a small code for a resistor-ladder DAC. The upper DAC bits carry the channel number, which sets the base level of a trace: channel 0 sits lowest and the highest channel sits on top. The lowest DAC bit carries the logic level of that channel in the current sample.

For one channel the sequencer walks every buffer address once, one sample per display clock. It then moves to the next channel and walks the buffer again. A separate trigger output pulses at the first sample of each channel's pass, so an externally triggered scope restarts its sweep for every trace. Afterglow on the screen makes the traces look simultaneous. While the run input is low, the display is blanked and the counters are parked at their start point. When the run input is raised, the display starts with channel 0 at address 0.

The memory read latency is a parameter. With the default of one cycle, the memory registers the address and its data appears on the following cycle.

Top module: `scope_trace_sequencer`

## Requirements
- R1: After reset, `rd_addr`, `dac_code` and `scope_trig` are all zero.
- R2: While `run_en` is high, `rd_addr` advances by one on every clock from 0 to DEPTH-1 and then wraps to 0. It never exceeds DEPTH-1.
- R3: Channels are shown in the order 0, 1, …, NCH-1, then 0 again. The channel advances only when the address wraps. The channel number appears in `dac_code` bits [CW:1], where CW is the channel field width (bits [2:1] for the default of 4 channels).
- R4: `dac_code` bit 0 equals bit `c` of the sample read from the address being shown, where `c` is the channel in bits [CW:1].
- R5: `scope_trig` is high for exactly one clock per channel pass. It is high exactly when `dac_code` shows the address-0 sample.
- R6: With READ_LAT = 1, the sample for the address presented in the cycle before clock edge n appears on `dac_code` after edge n+1.
- R7: When `run_en` is low at a clock edge, `rd_addr` is 0 after that edge. From the following edge, `dac_code` is 0 and `scope_trig` is low.
- R8: When `run_en` rises again, the display restarts at channel 0, address 0, and raises `scope_trig` for that first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| run_en | input | 1 | High to replay the buffer; low blanks the display and parks the counters |
| rd_data | input | NCH | Sample word from the memory; bit i is channel i |
| rd_addr | output | AW | Sample memory read address |
| dac_code | output | CW+1 | DAC code: channel number above, channel level in bit 0 |
| scope_trig | output | 1 | One-clock sweep restart pulse at the start of each channel pass |

## Verification
A corrupted address or channel counter shows at the ports within one clock on `rd_addr`. After two clocks, it shows as a wrong level or wrong channel field on `dac_code`. The memory pattern is a permutation of all sample values per pass, so every channel bit takes both levels at many addresses, and a swapped channel select or misaligned read shows as a wrong bit 0 within a few samples. A trigger that fires at the wrong address, or not once per pass, is caught on the first pass of channel 0. A wrong restart point after re-enable shows on the first displayed sample.

// File: rtl/scope_seq_pkg.sv
package scope_seq_pkg;

  // Width of an index field; never less than one bit.
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

  // Tag carried along the read pipeline with each address.
  typedef struct packed {
    logic live;   // display running for this sample
    logic first;  // sample at address zero
  } samp_tag_t;

endpackage

// File: rtl/seq_sweep_counter.sv
module seq_sweep_counter
  import scope_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NCH   = 4,
  parameter int AW    = idx_width(DEPTH),
  parameter int CW    = idx_width(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] chan,
  output samp_tag_t     tag
);

  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CHAN_LAST = CW'(NCH - 1);

  logic [AW-1:0] addr_q, addr_n;
  logic [CW-1:0] chan_q, chan_n;
  logic          addr_wrap;

  always_comb begin
    addr_wrap = (addr_q == ADDR_LAST);
    addr_n    = addr_q;
    chan_n    = chan_q;
    if (!run_en) begin
      addr_n = '0;
      chan_n = '0;
    end else begin
      addr_n = addr_wrap ? '0 : addr_q + 1'b1;
      if (addr_wrap) begin
        chan_n = (chan_q == CHAN_LAST) ? '0 : chan_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      chan_q <= '0;
    end else begin
      addr_q <= addr_n;
      chan_q <= chan_n;
    end
  end

  assign addr      = addr_q;
  assign chan      = chan_q;
  assign tag.live  = run_en;
  assign tag.first = (addr_q == '0);

endmodule

// File: rtl/seq_read_align.sv
module seq_read_align
  import scope_seq_pkg::*;
#(
  parameter int CW       = 2,
  parameter int READ_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] chan_in,
  input  samp_tag_t     tag_in,
  output logic [CW-1:0] chan_out,
  output samp_tag_t     tag_out
);

  generate
    if (READ_LAT == 0) begin : g_comb_read
      assign chan_out = chan_in;
      assign tag_out  = tag_in;
    end else begin : g_reg_read
      logic [CW-1:0] chan_q;
      samp_tag_t     tag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chan_q <= '0;
          tag_q  <= '0;
        end else begin
          chan_q <= chan_in;
          tag_q  <= tag_in;
        end
      end
      assign chan_out = chan_q;
      assign tag_out  = tag_q;
    end
  endgenerate

endmodule

// File: rtl/seq_dac_encoder.sv
module seq_dac_encoder
  import scope_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = idx_width(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  chan,
  input  samp_tag_t      tag,
  input  logic [NCH-1:0] sample,
  output logic [CW:0]    dac_code,
  output logic           trig
);

  logic [CW:0] dac_n, dac_q;
  logic        trig_n, trig_q;

  always_comb begin
    dac_n  = '0;
    trig_n = 1'b0;
    if (tag.live) begin
      dac_n  = {chan, sample[chan]};
      trig_n = tag.first;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      dac_q  <= dac_n;
      trig_q <= trig_n;
    end
  end

  assign dac_code = dac_q;
  assign trig     = trig_q;

endmodule

// File: rtl/scope_trace_sequencer.sv
module scope_trace_sequencer
  import scope_seq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int NCH      = 4,
  parameter int READ_LAT = 1,
  localparam int AW      = idx_width(DEPTH),
  localparam int CW      = idx_width(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic [NCH-1:0] rd_data,
  output logic [AW-1:0]  rd_addr,
  output logic [CW:0]    dac_code,
  output logic           scope_trig
);

  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic [CW-1:0] chan_cnt, chan_al;
  samp_tag_t     tag_cnt, tag_al;

  seq_sweep_counter #(
    .DEPTH (DEPTH),
    .NCH   (NCH),
    .AW    (AW),
    .CW    (CW)
  ) sweep_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_en (run_en),
    .addr   (rd_addr),
    .chan   (chan_cnt),
    .tag    (tag_cnt)
  );

  seq_read_align #(
    .CW       (CW),
    .READ_LAT (READ_LAT)
  ) align_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .chan_in  (chan_cnt),
    .tag_in   (tag_cnt),
    .chan_out (chan_al),
    .tag_out  (tag_al)
  );

  seq_dac_encoder #(
    .NCH (NCH),
    .CW  (CW)
  ) enc_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .chan     (chan_al),
    .tag      (tag_al),
    .sample   (rd_data),
    .dac_code (dac_code),
    .trig     (scope_trig)
  );

endmodule

// File: rtl/scope_trace_sequencer_chk.sv
module scope_trace_sequencer_chk #(
  parameter int DEPTH    = 16,
  parameter int NCH      = 4,
  parameter int READ_LAT = 1,
  parameter int AW       = 4,
  parameter int CW       = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic [AW-1:0] rd_addr,
  input logic [CW:0]   dac_code,
  input logic          scope_trig
);

  // R2
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr <= AW'(DEPTH - 1));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && rd_addr != AW'(DEPTH - 1)) |=> (rd_addr == AW'($past(rd_addr) + 1'b1)));

  // R2
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && rd_addr == AW'(DEPTH - 1)) |=> (rd_addr == '0));

  // R7
  addr_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (rd_addr == '0));

  // R5
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scope_trig |=> !scope_trig);

  // R7
  generate
    if (READ_LAT == 0) begin : g_blank0
      blank_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (dac_code == '0 && !scope_trig));
    end else begin : g_blank1
      blank_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> ##2 (dac_code == '0 && !scope_trig));
    end
  endgenerate

endmodule

bind scope_trace_sequencer scope_trace_sequencer_chk #(
  .DEPTH    (DEPTH),
  .NCH      (NCH),
  .READ_LAT (READ_LAT),
  .AW       (AW),
  .CW       (CW)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .rd_addr    (rd_addr),
  .dac_code   (dac_code),
  .scope_trig (scope_trig)
);

// File: tb/scope_trace_sequencer_tb_top.sv
`timescale 1ns/1ps
module scope_trace_sequencer_tb_top;

  localparam int DEPTH = 16;
  localparam int NCH   = 4;
  localparam int AW    = 4;
  localparam int CW    = 2;

  logic           clk;
  logic           rst_n;
  logic           run_en;
  logic [NCH-1:0] rd_data;
  logic [AW-1:0]  rd_addr;
  logic [CW:0]    dac_code;
  logic           scope_trig;

  logic [NCH-1:0] mem [DEPTH];

  int checks;
  int fails;

  scope_trace_sequencer #(
    .DEPTH    (DEPTH),
    .NCH      (NCH),
    .READ_LAT (1)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .dac_code   (dac_code),
    .scope_trig (scope_trig)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Sample memory with one cycle of read latency.
  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic load_mem(input int pat);
    for (int a = 0; a < DEPTH; a++) begin
      if (pat == 0) mem[a] = NCH'((a * 7 + 3) % 16);
      else          mem[a] = NCH'((a * 11 + 6) % 16);
    end
  endtask

  // Drive run_en high and check a given number of displayed samples.
  task automatic run_sweep(input int nsamp, input string tag);
    @(negedge clk);
    run_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R6: the first edge with run_en high still shows a blank output
    chk("R6", {tag, " first-edge dac"}, int'(dac_code), 0);
    chk("R2", {tag, " addr after first edge"}, int'(rd_addr), 1);
    for (int j = 1; j <= nsamp; j++) begin
      int k, a, c, lvl;
      @(posedge clk);
      @(negedge clk);
      k   = j - 1;
      a   = k % DEPTH;
      c   = (k / DEPTH) % NCH;
      lvl = int'(mem[a][c]);
      chk("R2", {tag, " rd_addr"}, int'(rd_addr), (j + 1) % DEPTH);
      chk("R3", {tag, " channel field"}, int'(dac_code[CW:1]), c);
      chk("R4", {tag, " level bit"}, int'(dac_code[0]), lvl);
      chk("R5", {tag, " trigger"}, int'(scope_trig), (a == 0) ? 1 : 0);
      if (j == 1) begin
        // R8: restart at channel 0, address 0, with trigger
        chk("R8", {tag, " restart channel"}, int'(dac_code[CW:1]), 0);
        chk("R8", {tag, " restart trigger"}, int'(scope_trig), 1);
      end
    end
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    run_en = 1'b0;
    load_mem(0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1
    chk("R1", "reset rd_addr", int'(rd_addr), 0);
    chk("R1", "reset dac_code", int'(dac_code), 0);
    chk("R1", "reset scope_trig", int'(scope_trig), 0);

    // Two full frames over all channels and addresses.
    run_sweep(2 * NCH * DEPTH + 5, "frame A");

    // R7: drop run_en mid-pass
    @(negedge clk);
    run_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R7", "addr parked", int'(rd_addr), 0);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R7", "blank dac", int'(dac_code), 0);
      chk("R7", "blank trig", int'(scope_trig), 0);
      chk("R7", "addr held", int'(rd_addr), 0);
    end

    // R8: new contents, restart from the beginning
    load_mem(1);
    run_sweep(NCH * DEPTH + 3, "frame B");

    @(negedge clk);
    run_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", "final blank", int'(dac_code), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule